// File: doc/BRIEF.md
# Symmetric Up-Down PWM Generator

This block drives one pulse-width-modulated output from a triangle counter. The counter rises from zero to a programmable period value and falls back to zero, over and over. Its step rate comes from the system clock through two dividers in series: a fine divider, then a power-of-two divider. Each time the counter takes one step, one prescaled tick has passed.

A compare value is written into a holding register. The value that is actually used is copied from the holding register only when the counter returns to zero, so a new duty cycle never takes effect part-way through a carrier cycle. When the counter meets the compare value, a configurable action is applied to the output. There is one action for the rising half of the cycle and another for the falling half.

The block also gives out the counting direction and two single-cycle strobes, one at counter-zero and one at counter-equals-period. A trip or protection stage further along can use them.

Top module: `ud_pwm_gen`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `pwm_out`, `dir_down`, `zero_stb` and `prd_stb` are all 0.
- R2: For a nonzero period P, the counter steps 0,1,...,P,P-1,...,1 and then returns to 0. One carrier cycle lasts 2·P ticks and produces exactly one `zero_stb` and one `prd_stb`.
- R3: One tick lasts H·L system clock cycles. H is 1 when `hs_div` is 0 and 2·`hs_div` otherwise. L is 2 raised to the power `lo_div`.
- R4: `dir_down` goes to 1 on the same edge that the counter reaches P, and goes to 0 on the same edge that it reaches 0. Therefore `prd_stb` is only ever seen with `dir_down`=1, and `zero_stb` only with `dir_down`=0.
- R5: Each strobe is high for one system clock cycle: the first cycle in which the counter holds 0 (for `zero_stb`) or P (for `prd_stb`).
- R6: A `cmp_wr` pulse stores `cmp_wdata` in a holding register. The value in use changes only when the counter steps to 0 or when `ctr_clr` is applied; a write made mid-cycle therefore governs the following carrier cycle.
- R7: The action codes are 0 = no change, 1 = drive low, 2 = drive high and 3 = invert. A match while the counter is rising applies `act_up`; a match while it is falling applies `act_dn`. The output changes on the edge that ends the matching tick.
- R8: With drive-high on the rise and drive-low on the fall, and a compare value C with 0<C<P, the output is high for 2·(P−C) ticks of each carrier cycle. With C=0 it is high for the whole cycle; with C=P it stays low; with C>P there are no matches and the output holds its level.
- R9: `ctr_clr` sets the counter to 0, sets the direction to up, restarts both dividers and loads the held compare value. The next `zero_stb` appears 2·P·H·L cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_div | input | 3 | Fine divider code (0 gives /1, n gives /2n) |
| lo_div | input | 3 | Power-of-two divider code (/2^n) |
| period | input | CNT_W | Top value of the triangle counter |
| ctr_clr | input | 1 | Forces the counter to zero and restarts the cycle |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | CNT_W | Compare value to hold |
| act_up | input | 2 | Action on a compare match while rising |
| act_dn | input | 2 | Action on a compare match while falling |
| pwm_out | output | 1 | PWM output |
| dir_down | output | 1 | 1 while counting down |
| zero_stb | output | 1 | One-cycle counter-zero strobe |
| prd_stb | output | 1 | One-cycle counter-at-period strobe |

## Verification
The checks assume two things about the inputs. First, the divider codes and the period stay fixed during a carrier cycle, and they are changed only just before a `ctr_clr`. Second, the period is nonzero while the strobe-width and direction properties are in force. The stimulus follows both rules. Each table row and each directed test drives its configuration, writes the compare value and pulses `ctr_clr`, and only then starts measuring. Every period it uses is at least 3. Measurements start at a zero strobe, so the first, partial carrier cycle after a reconfiguration is never scored.

// File: rtl/ud_pwm_pkg.sv
package ud_pwm_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_INV  = 2'd3
  } pwm_act_e;
endpackage

// File: rtl/ud_prescaler.sv
module ud_prescaler #(
  parameter int HS_W = 3,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [HS_W-1:0] hs_div,
  input  logic [LO_W-1:0] lo_div,
  output logic            tick
);
  localparam int HS_CNT_W = HS_W + 1;
  localparam int LO_CNT_W = 1 << LO_W;

  logic [HS_CNT_W-1:0] hs_cnt_q, hs_cnt_d, hs_lim;
  logic [LO_CNT_W-1:0] lo_cnt_q, lo_cnt_d, lo_lim;
  logic                hs_done, lo_done;

  always_comb begin
    hs_lim  = (hs_div == '0) ? HS_CNT_W'(1) : {hs_div, 1'b0};
    lo_lim  = LO_CNT_W'(1) << lo_div;
    hs_done = (hs_cnt_q == hs_lim - HS_CNT_W'(1));
    lo_done = (lo_cnt_q == lo_lim - LO_CNT_W'(1));
    tick    = hs_done && lo_done;
  end

  always_comb begin
    hs_cnt_d = hs_cnt_q;
    lo_cnt_d = lo_cnt_q;
    if (restart) begin
      hs_cnt_d = '0;
      lo_cnt_d = '0;
    end else if (hs_done) begin
      hs_cnt_d = '0;
      lo_cnt_d = lo_done ? '0 : lo_cnt_q + LO_CNT_W'(1);
    end else begin
      hs_cnt_d = hs_cnt_q + HS_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else begin
      hs_cnt_q <= hs_cnt_d;
      lo_cnt_q <= lo_cnt_d;
    end
  end
endmodule

// File: rtl/ud_timebase.sv
module ud_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctr_clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] ctr,
  output logic             down,
  output logic             at_zero_next,
  output logic             zero_stb,
  output logic             prd_stb
);
  logic [CNT_W-1:0] ctr_q, ctr_d;
  logic             down_q, down_d;
  logic             zero_q, zero_d, prd_q, prd_d;

  always_comb begin
    ctr_d  = ctr_q;
    down_d = down_q;
    zero_d = 1'b0;
    prd_d  = 1'b0;
    if (ctr_clr) begin
      ctr_d  = '0;
      down_d = 1'b0;
    end else if (tick) begin
      if (period == '0) begin
        ctr_d  = '0;
        down_d = 1'b0;
        zero_d = 1'b1;
      end else begin
        if (!down_q && (ctr_q < period)) begin
          ctr_d  = ctr_q + CNT_W'(1);
          down_d = (ctr_d == period);
        end else if (ctr_q == '0) begin
          ctr_d  = CNT_W'(1);
          down_d = (ctr_d == period);
        end else begin
          ctr_d  = ctr_q - CNT_W'(1);
          down_d = (ctr_d != '0);
        end
        zero_d = (ctr_d == '0);
        prd_d  = (ctr_d == period);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q  <= '0;
      down_q <= 1'b0;
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      ctr_q  <= ctr_d;
      down_q <= down_d;
      zero_q <= zero_d;
      prd_q  <= prd_d;
    end
  end

  assign ctr          = ctr_q;
  assign down         = down_q;
  assign at_zero_next = zero_d;
  assign zero_stb     = zero_q;
  assign prd_stb      = prd_q;
endmodule

// File: rtl/ud_cmp_shadow.sv
module ud_cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] cmp_act
);
  logic [CNT_W-1:0] hold_q, hold_d, act_q, act_d;

  always_comb begin
    hold_d = wr_en ? wr_data : hold_q;
    act_d  = load  ? hold_q  : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  assign cmp_act = act_q;
endmodule

// File: rtl/ud_action.sv
module ud_action
  import ud_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctr_clr,
  input  logic [CNT_W-1:0] ctr,
  input  logic             down,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic [1:0]       act_up,
  input  logic [1:0]       act_dn,
  output logic             pwm
);
  logic     pwm_q, pwm_d, hit;
  pwm_act_e code;

  always_comb begin
    hit   = tick && !ctr_clr && (ctr == cmp_act);
    code  = pwm_act_e'(down ? act_dn : act_up);
    pwm_d = pwm_q;
    if (hit) begin
      unique case (code)
        ACT_NONE: pwm_d = pwm_q;
        ACT_LOW:  pwm_d = 1'b0;
        ACT_HIGH: pwm_d = 1'b1;
        ACT_INV:  pwm_d = ~pwm_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/ud_pwm_gen.sv
module ud_pwm_gen #(
  parameter int CNT_W       = 16,
  parameter int HS_W        = 3,
  parameter int LO_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HS_W-1:0]  hs_div,
  input  logic [LO_W-1:0]  lo_div,
  input  logic [CNT_W-1:0] period,
  input  logic             ctr_clr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       act_up,
  input  logic [1:0]       act_dn,
  output logic             pwm_out,
  output logic             dir_down,
  output logic             zero_stb,
  output logic             prd_stb
);
  localparam int SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_q;
  logic              tick_w, load_zero;
  logic [CNT_W-1:0]  ctr_w, cmp_act_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_q = rst_sync_q[SYNC_N-1];

  ud_prescaler #(.HS_W(HS_W), .LO_W(LO_W)) presc_i (
    .clk(clk), .rst_n(rst_q), .restart(ctr_clr),
    .hs_div(hs_div), .lo_div(lo_div), .tick(tick_w)
  );

  ud_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_q), .tick(tick_w), .ctr_clr(ctr_clr),
    .period(period), .ctr(ctr_w), .down(dir_down),
    .at_zero_next(load_zero), .zero_stb(zero_stb), .prd_stb(prd_stb)
  );

  ud_cmp_shadow #(.CNT_W(CNT_W)) cmp_i (
    .clk(clk), .rst_n(rst_q), .wr_en(cmp_wr), .wr_data(cmp_wdata),
    .load(ctr_clr || load_zero), .cmp_act(cmp_act_w)
  );

  ud_action #(.CNT_W(CNT_W)) aq_i (
    .clk(clk), .rst_n(rst_q), .tick(tick_w), .ctr_clr(ctr_clr),
    .ctr(ctr_w), .down(dir_down), .cmp_act(cmp_act_w),
    .act_up(act_up), .act_dn(act_dn), .pwm(pwm_out)
  );
endmodule

// File: rtl/ud_pwm_gen_chk.sv
module ud_pwm_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctr_clr,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_out,
  input logic             dir_down,
  input logic             zero_stb,
  input logic             prd_stb
);
  AST_PRD_WHILE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    prd_stb |-> dir_down); // R4
  AST_ZERO_WHILE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    zero_stb |-> !dir_down); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_stb && prd_stb)); // R2
  AST_ZERO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_stb && period != '0) |=> !zero_stb); // R5
  AST_PRD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prd_stb |=> !prd_stb); // R5
  AST_PWM_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out)); // R7
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctr_clr) |=> $stable(cmp_act)); // R6
endmodule

bind ud_pwm_gen ud_pwm_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_q), .tick(tick_w), .ctr_clr(ctr_clr),
  .period(period), .cmp_act(cmp_act_w), .pwm_out(pwm_out),
  .dir_down(dir_down), .zero_stb(zero_stb), .prd_stb(prd_stb)
);

// File: tb/ud_pwm_gen_tb_top.sv
module ud_pwm_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WDOG_LIMIT = 150000;

  typedef struct packed {
    logic [2:0]  hs;
    logic [2:0]  lo;
    logic [15:0] prd;
    logic [15:0] cmp;
    logic [1:0]  au;
    logic [1:0]  ad;
    logic [15:0] hi_ticks;   // 16'hFFFF = level not scored
    logic [3:0]  edges;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 16'd8,  16'd3, 2'd2, 2'd1, 16'd10,     4'd2},
    '{3'd1, 3'd1, 16'd6,  16'd2, 2'd2, 2'd1, 16'd8,      4'd2},
    '{3'd3, 3'd2, 16'd5,  16'd1, 2'd2, 2'd1, 16'd8,      4'd2},
    '{3'd0, 3'd3, 16'd10, 16'd0, 2'd2, 2'd1, 16'd20,     4'd0},
    '{3'd0, 3'd0, 16'd10, 16'd10,2'd2, 2'd1, 16'd0,      4'd0},
    '{3'd2, 3'd0, 16'd6,  16'd9, 2'd2, 2'd1, 16'hFFFF,   4'd0},
    '{3'd0, 3'd0, 16'd8,  16'd2, 2'd1, 2'd2, 16'd4,      4'd2},
    '{3'd0, 3'd0, 16'd7,  16'd3, 2'd3, 2'd0, 16'hFFFF,   4'd1},
    '{3'd0, 3'd0, 16'd6,  16'd3, 2'd0, 2'd0, 16'hFFFF,   4'd0},
    '{3'd7, 3'd0, 16'd4,  16'd2, 2'd2, 2'd1, 16'd4,      4'd2}
  };

  logic             clk, rst_n;
  logic [2:0]       hs_div, lo_div;
  logic [CNT_W-1:0] period, cmp_wdata;
  logic             ctr_clr, cmp_wr;
  logic [1:0]       act_up, act_dn;
  logic             pwm_out, dir_down, zero_stb, prd_stb;

  int n_checks, n_fail;
  bit finished;

  ud_pwm_gen #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_div(hs_div), .lo_div(lo_div),
    .period(period), .ctr_clr(ctr_clr), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .act_up(act_up), .act_dn(act_dn),
    .pwm_out(pwm_out), .dir_down(dir_down), .zero_stb(zero_stb),
    .prd_stb(prd_stb)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic int tick_len(input logic [2:0] hs, input logic [2:0] lo);
    int h;
    h = (hs == 3'd0) ? 1 : 2 * int'(hs);
    return h * (1 << lo);
  endfunction

  // drive configuration, hold a compare value, clear the counter;
  // returns on the first negedge after the clear edge
  task automatic setup(input logic [2:0] hs, input logic [2:0] lo,
                       input logic [15:0] prd, input logic [15:0] cmp,
                       input logic [1:0] au, input logic [1:0] ad);
    @(negedge clk);
    hs_div = hs; lo_div = lo; period = prd;
    act_up = au; act_dn = ad;
    cmp_wdata = cmp; cmp_wr = 1'b1;
    @(negedge clk);
    cmp_wr = 1'b0; ctr_clr = 1'b1;
    @(negedge clk);
    ctr_clr = 1'b0;
  endtask

  task automatic wait_zero(output int cyc);
    cyc = 0;
    while (!zero_stb && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic measure(input int n, output int hi, output int zs,
                         output int ps, output int ed);
    logic prev;
    hi = 0; zs = 0; ps = 0; ed = 0;
    prev = pwm_out;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (zero_stb) zs++;
      if (prd_stb) ps++;
      if (pwm_out != prev) ed++;
      prev = pwm_out;
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > WDOG_LIMIT) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, WDOG_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    int cyc, hi, zs, ps, ed, t, n;
    n_checks = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; ctr_clr = 1'b0; cmp_wr = 1'b0; cmp_wdata = '0;
    hs_div = '0; lo_div = '0; period = 16'd8; act_up = 2'd2; act_dn = 2'd1;

    // R1: outputs quiet in reset and just after release
    repeat (3) @(negedge clk);
    check(!pwm_out && !dir_down && !zero_stb && !prd_stb, "R1 in reset",
          {pwm_out, dir_down, zero_stb, prd_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pwm_out && !dir_down && !zero_stb && !prd_stb, "R1 after release",
          {pwm_out, dir_down, zero_stb, prd_stb}, 0);
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      t = tick_len(VECS[v].hs, VECS[v].lo);
      n = 2 * int'(VECS[v].prd) * t;
      setup(VECS[v].hs, VECS[v].lo, VECS[v].prd, VECS[v].cmp, VECS[v].au, VECS[v].ad);
      check(!dir_down, "R9 direction up after clear", dir_down, 0);
      wait_zero(cyc);
      check(cyc == n, "R3 R9 first zero strobe delay", cyc, n);
      measure(n, hi, zs, ps, ed);
      check(zs == 1 && zero_stb, "R2 one zero strobe per cycle", zs, 1);
      check(ps == 1, "R2 one period strobe per cycle", ps, 1);
      check(ed == int'(VECS[v].edges), "R7 output edges per cycle", ed, int'(VECS[v].edges));
      if (VECS[v].hi_ticks != 16'hFFFF)
        check(hi == int'(VECS[v].hi_ticks) * t, "R8 high cycles per carrier cycle",
              hi, int'(VECS[v].hi_ticks) * t);
    end

    // R4 R5: direction and strobe placement, P=3, one clock per tick
    setup(3'd0, 3'd0, 16'd3, 16'd1, 2'd2, 2'd1);
    wait_zero(cyc);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check(dir_down == (k >= 3 && k <= 5), "R4 direction sequence",
            dir_down, (k >= 3 && k <= 5));
      check(prd_stb == (k == 3), "R5 period strobe cycle", prd_stb, (k == 3));
      check(zero_stb == (k == 6), "R5 zero strobe cycle", zero_stb, (k == 6));
    end

    // R6: mid-cycle compare write takes effect at the next zero
    setup(3'd0, 3'd0, 16'd8, 16'd2, 2'd2, 2'd1);
    wait_zero(cyc);
    hi = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (k == 3) begin cmp_wdata = 16'd6; cmp_wr = 1'b1; end
      if (k == 4) cmp_wr = 1'b0;
    end
    check(hi == 12, "R6 old compare governs current cycle", hi, 12);
    check(zero_stb, "R6 window aligned to zero", zero_stb, 1);
    measure(16, hi, zs, ps, ed);
    check(hi == 4, "R6 new compare governs next cycle", hi, 4);

    // R9: clear in the falling half restarts a full cycle
    setup(3'd0, 3'd1, 16'd5, 16'd2, 2'd2, 2'd1);
    repeat (14) @(negedge clk);
    check(dir_down, "R9 setup reached falling half", dir_down, 1);
    @(negedge clk); ctr_clr = 1'b1;
    @(negedge clk); ctr_clr = 1'b0;
    check(!dir_down, "R9 clear forces up", dir_down, 0);
    wait_zero(cyc);
    check(cyc == 20, "R9 full cycle after mid-run clear", cyc, 20);

    finish_run();
  end
endmodule